// File: doc/BRIEF.md
# ECC-Protected Word Memory with Byte Lanes

A word-addressed static memory with a 16-bit data path, sampled on a clock. Two chip-select pins (one active low, one active high), an active-low write strobe, an active-low output strobe and two active-low byte-lane selects control the access. Each 16-bit word is kept as a 21-bit single-error-correcting Hamming codeword. Every read corrects one flipped bit anywhere in the codeword and raises an error flag for that read only. The corrected value goes only to the output and never back into storage.

The data bus that would be tri-stated in a discrete part is modelled as a data-out vector plus a per-lane valid pair. A lane that does not drive reads as zero. A write that touches only one lane reads the stored word, corrects it, merges in the new byte and re-encodes the whole word, so the check bits always cover all 16 bits. A test port can XOR a mask into any stored codeword to plant faults. Depth is a parameter, so the array can be much smaller than the full 18-bit address space.

Top module: `ecc_sram`

## Requirements
- R1: The part is selected only when `cs_a_n`=0 and `cs_b`=1. With any other combination no lane is driven and no write changes storage.
- R2: A selected write (`wr_n`=0) with both lanes enabled stores `wdata`. A later selected read (`wr_n`=1, `rd_n`=0) returns that word on `rdata`, with `lane_ok` valid on the cycle after the edge that sampled the read.
- R3: `hi_n`=0 enables bits 15..8 and `lo_n`=0 enables bits 7..0 for writes. A disabled lane keeps its stored byte.
- R4: On a read, `lane_ok[1]` = not `hi_n` and `lane_ok[0]` = not `lo_n`. The bits of a lane that is not driven read 0.
- R5: A read with `rd_n`=1, or with both lane selects high, drives no lane and keeps `ecc_err` low.
- R6: When `wr_n`=0 and `rd_n`=0 in the same cycle, the write takes effect, no lane is driven and `ecc_err` stays low.
- R7: A single flipped bit at any of the 21 codeword positions is corrected on read, and `ecc_err`=1 for that read.
- R8: A corrected error is not written back. Repeated reads of a faulty word flag again. A fault-free word reads with `ecc_err`=0.
- R9: A one-lane write to a word holding a single-bit fault corrects the untouched byte and stores a clean codeword. Later reads return the merged word with `ecc_err`=0.
- R10: `inj_en`=1 XORs `inj_mask` into the stored codeword at `inj_addr` at the clock edge. Mask bit i is codeword position i+1. Check bits sit at positions 1, 2, 4, 8 and 16, and data bits 0..15 fill the remaining positions in ascending order. A write in the same cycle takes precedence and the injection is dropped.
- R11: While `rst` is high, `lane_ok`, `rdata` and `ecc_err` are all zero.
- R12: Only the low log2(DEPTH) address bits select the word, so addresses that differ by DEPTH reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_a_n | input | 1 | Chip select, active low |
| cs_b | input | 1 | Chip select, active high |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Output strobe, active low |
| hi_n | input | 1 | Upper byte lane select, active low |
| lo_n | input | 1 | Lower byte lane select, active low |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data; bits of undriven lanes are 0 |
| lane_ok | output | 2 | Per-lane output valid, bit 1 upper |
| ecc_err | output | 1 | Corrected single-bit error on this read |
| inj_en | input | 1 | Fault injection strobe |
| inj_addr | input | ADDR_W | Fault injection word address |
| inj_mask | input | 21 | Codeword XOR mask |

## Verification
The bench plants a one-bit fault at every one of the 21 codeword positions. A decoder with a misplaced check bit or a wrong syndrome-to-position map would return wrong data there or leave the flag low. It reads a faulty word twice, which catches a design that quietly scrubs on read. It also writes one lane over a faulty word, which catches a merge that re-encodes the uncorrected byte and so leaves a permanent fault or corrupts the other lane. Strobe conflicts, deselect combinations, lane masking, a write colliding with an injection, and address aliasing each target a design that drives data or commits a write when it should not.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;
    localparam int DATA_W = 16;
    localparam int NPAR   = 5;
    localparam int CW_W   = DATA_W + NPAR;

    typedef logic [DATA_W-1:0] word_t;
    typedef logic [CW_W-1:0]   cw_t;
    typedef logic [NPAR-1:0]   synd_t;

    typedef struct packed {
        logic       rd;
        logic       wr;
        logic [1:0] lanes;
    } op_t;

    typedef struct packed {
        word_t data;
        logic  err;
    } dec_t;

    function automatic logic is_pow2(int p);
        return (p & (p - 1)) == 0;
    endfunction

    function automatic synd_t syndrome(cw_t cw);
        synd_t s = '0;
        for (int p = 1; p <= CW_W; p++)
            if (cw[p-1]) s ^= p[NPAR-1:0];
        return s;
    endfunction

    function automatic cw_t encode(word_t d);
        cw_t   cw = '0;
        synd_t s;
        int    j  = 0;
        for (int p = 1; p <= CW_W; p++) begin
            if (!is_pow2(p)) begin
                cw[p-1] = d[j];
                j++;
            end
        end
        s = syndrome(cw);
        for (int k = 0; k < NPAR; k++)
            cw[(1 << k) - 1] = s[k];
        return cw;
    endfunction

    function automatic dec_t decode(cw_t cw);
        dec_t  r;
        synd_t s = syndrome(cw);
        cw_t   c = cw;
        int    j = 0;
        if (s != '0 && int'(s) <= CW_W)
            c[int'(s) - 1] = ~c[int'(s) - 1];
        r.data = '0;
        for (int p = 1; p <= CW_W; p++) begin
            if (!is_pow2(p)) begin
                r.data[j] = c[p-1];
                j++;
            end
        end
        r.err = (s != '0);
        return r;
    endfunction
endpackage

// File: rtl/ecc_sram_ctrl.sv
module ecc_sram_ctrl
    import ecc_sram_pkg::*;
(
    input  logic cs_a_n,
    input  logic cs_b,
    input  logic wr_n,
    input  logic rd_n,
    input  logic hi_n,
    input  logic lo_n,
    output op_t  op
);
    logic       sel;
    logic [1:0] lanes;

    always_comb begin
        sel      = !cs_a_n && cs_b;
        lanes    = {!hi_n, !lo_n};
        op.lanes = lanes;
        op.wr    = sel && !wr_n && (lanes != 2'b00);
        op.rd    = sel && wr_n && !rd_n && (lanes != 2'b00);
    end
endmodule

// File: rtl/ecc_sram_array.sv
module ecc_sram_array
    import ecc_sram_pkg::*;
#(
    parameter int DEPTH = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  cw_t              wr_cw,
    input  logic             inj_en,
    input  logic [IDX_W-1:0] inj_idx,
    input  cw_t              inj_mask,
    input  logic [IDX_W-1:0] rd_idx,
    output cw_t              rd_cw
);
    cw_t mem [DEPTH];

    initial begin
        for (int i = 0; i < DEPTH; i++) mem[i] = '0;
    end

    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_idx] <= wr_cw;
        else if (inj_en)
            mem[inj_idx] <= mem[inj_idx] ^ inj_mask;
    end

    assign rd_cw = mem[rd_idx];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> mem[$past(wr_idx)] == $past(wr_cw)); // R2
endmodule

// File: rtl/ecc_sram.sv
module ecc_sram
    import ecc_sram_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DEPTH  = 1024,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_a_n,
    input  logic              cs_b,
    input  logic              wr_n,
    input  logic              rd_n,
    input  logic              hi_n,
    input  logic              lo_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic [1:0]        lane_ok,
    output logic              ecc_err,
    input  logic              inj_en,
    input  logic [ADDR_W-1:0] inj_addr,
    input  logic [20:0]       inj_mask
);
    op_t   op;
    cw_t   cur_cw;
    cw_t   new_cw;
    dec_t  cur;
    word_t merged;
    word_t lane_mask;

    ecc_sram_ctrl u_ctrl (
        .cs_a_n(cs_a_n), .cs_b(cs_b), .wr_n(wr_n), .rd_n(rd_n),
        .hi_n(hi_n), .lo_n(lo_n), .op(op)
    );

    ecc_sram_array #(.DEPTH(DEPTH)) u_array (
        .clk(clk), .rst(rst),
        .wr_en(op.wr), .wr_idx(addr[IDX_W-1:0]), .wr_cw(new_cw),
        .inj_en(inj_en), .inj_idx(inj_addr[IDX_W-1:0]), .inj_mask(inj_mask),
        .rd_idx(addr[IDX_W-1:0]), .rd_cw(cur_cw)
    );

    always_comb begin
        cur       = decode(cur_cw);
        lane_mask = {{8{op.lanes[1]}}, {8{op.lanes[0]}}};
        merged    = (wdata & lane_mask) | (cur.data & ~lane_mask);
        new_cw    = encode(merged);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata   <= '0;
            lane_ok <= '0;
            ecc_err <= 1'b0;
        end else if (op.rd) begin
            rdata   <= cur.data & lane_mask;
            lane_ok <= op.lanes;
            ecc_err <= cur.err;
        end else begin
            rdata   <= '0;
            lane_ok <= '0;
            ecc_err <= 1'b0;
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (lane_ok != 2'b00) |-> $past(!cs_a_n && cs_b && wr_n && !rd_n)); // R1
    AST_LANES_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (lane_ok != 2'b00) |-> lane_ok == $past({!hi_n, !lo_n})); // R4
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (rst)
        $past(!cs_a_n && cs_b && !wr_n) |-> (lane_ok == 2'b00 && !ecc_err)); // R6
    AST_ERR_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        ecc_err |-> (lane_ok != 2'b00)); // R7
endmodule

// File: tb/ecc_sram_tb.sv
module ecc_sram_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 18;
    localparam int DEPTH  = 1024;

    logic clk = 1'b0;
    logic rst;
    logic cs_a_n, cs_b, wr_n, rd_n, hi_n, lo_n;
    logic [ADDR_W-1:0] addr;
    logic [15:0] wdata;
    logic [15:0] rdata;
    logic [1:0]  lane_ok;
    logic        ecc_err;
    logic        inj_en;
    logic [ADDR_W-1:0] inj_addr;
    logic [20:0] inj_mask;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_sram #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst(rst), .cs_a_n(cs_a_n), .cs_b(cs_b), .wr_n(wr_n),
        .rd_n(rd_n), .hi_n(hi_n), .lo_n(lo_n), .addr(addr), .wdata(wdata),
        .rdata(rdata), .lane_ok(lane_ok), .ecc_err(ecc_err),
        .inj_en(inj_en), .inj_addr(inj_addr), .inj_mask(inj_mask)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        cs_a_n = 1'b1; cs_b = 1'b0; wr_n = 1'b1; rd_n = 1'b1;
        hi_n = 1'b1; lo_n = 1'b1; inj_en = 1'b0;
    endtask

    // Drives one access at a negedge; outputs are sampled at the next negedge.
    task automatic access(logic a_n, logic b, logic w_n, logic r_n, logic h_n,
                          logic l_n, logic [ADDR_W-1:0] a, logic [15:0] d);
        @(negedge clk);
        cs_a_n = a_n; cs_b = b; wr_n = w_n; rd_n = r_n;
        hi_n = h_n; lo_n = l_n; addr = a; wdata = d;
        @(negedge clk);
        idle();
    endtask

    task automatic write(logic [ADDR_W-1:0] a, logic [15:0] d, logic h_n, logic l_n);
        access(1'b0, 1'b1, 1'b0, 1'b1, h_n, l_n, a, d);
    endtask

    task automatic read_chk(string tag, logic [ADDR_W-1:0] a, logic h_n, logic l_n,
                            logic [15:0] exp_d, logic exp_err);
        access(1'b0, 1'b1, 1'b1, 1'b0, h_n, l_n, a, 16'h0);
        chk({tag, " data"}, 32'(rdata), 32'(exp_d));
        chk({tag, " lanes"}, 32'(lane_ok), 32'({!h_n, !l_n}));
        chk({tag, " err"}, 32'(ecc_err), 32'(exp_err));
    endtask

    task automatic inject(logic [ADDR_W-1:0] a, logic [20:0] m);
        @(negedge clk);
        inj_en = 1'b1; inj_addr = a; inj_mask = m;
        @(negedge clk);
        inj_en = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 rdata", 32'(rdata), 0);
        chk("R11 lane_ok", 32'(lane_ok), 0);
        chk("R11 ecc_err", 32'(ecc_err), 0);
    endtask

    task automatic t_full();
        write(18'd1, 16'hA5C3, 1'b0, 1'b0);
        write(18'd2, 16'hFFFF, 1'b0, 1'b0);
        write(18'd3, 16'h0001, 1'b0, 1'b0);
        read_chk("R2 word1", 18'd1, 1'b0, 1'b0, 16'hA5C3, 1'b0);
        read_chk("R2 word2", 18'd2, 1'b0, 1'b0, 16'hFFFF, 1'b0);
        read_chk("R8 clean word3", 18'd3, 1'b0, 1'b0, 16'h0001, 1'b0);
    endtask

    task automatic t_bytes();
        write(18'd10, 16'h1234, 1'b0, 1'b0);
        write(18'd10, 16'hAB99, 1'b0, 1'b1);
        read_chk("R3 upper lane write", 18'd10, 1'b0, 1'b0, 16'hAB34, 1'b0);
        write(18'd10, 16'h77CD, 1'b1, 1'b0);
        read_chk("R3 lower lane write", 18'd10, 1'b0, 1'b0, 16'hABCD, 1'b0);
        read_chk("R4 upper only read", 18'd10, 1'b0, 1'b1, 16'hAB00, 1'b0);
        read_chk("R4 lower only read", 18'd10, 1'b1, 1'b0, 16'h00CD, 1'b0);
    endtask

    task automatic t_quiet();
        write(18'd20, 16'h5A5A, 1'b0, 1'b0);
        access(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 18'd20, 16'h0);
        chk("R5 rd_n high lanes", 32'(lane_ok), 0);
        access(1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 18'd20, 16'h0);
        chk("R5 no lanes selected", 32'(lane_ok), 0);
        chk("R5 no lanes err", 32'(ecc_err), 0);
        access(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 18'd20, 16'h0);
        chk("R1 cs_a_n high read", 32'(lane_ok), 0);
        access(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 18'd20, 16'h0);
        chk("R1 cs_b low read", 32'(lane_ok), 0);
        access(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 18'd20, 16'hDEAD);
        access(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 18'd20, 16'hBEEF);
        read_chk("R1 deselected writes ignored", 18'd20, 1'b0, 1'b0, 16'h5A5A, 1'b0);
    endtask

    task automatic t_write_wins();
        access(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 18'd30, 16'hC0DE);
        chk("R6 no lanes on conflict", 32'(lane_ok), 0);
        chk("R6 err low on conflict", 32'(ecc_err), 0);
        read_chk("R6 write committed", 18'd30, 1'b0, 1'b0, 16'hC0DE, 1'b0);
    endtask

    task automatic t_inject();
        for (int pos = 0; pos < 21; pos++) begin
            logic [15:0] d = 16'h3C96 ^ 16'(pos * 16'h0101);
            write(18'd40, d, 1'b0, 1'b0);
            inject(18'd40, 21'(1) << pos);
            read_chk($sformatf("R7 fault pos %0d", pos), 18'd40, 1'b0, 1'b0, d, 1'b1);
        end
        read_chk("R8 repeat read flags again", 18'd40, 1'b0, 1'b0,
                 16'h3C96 ^ 16'(20 * 16'h0101), 1'b1);
    endtask

    task automatic t_partial_fix();
        write(18'd50, 16'h1357, 1'b0, 1'b0);
        inject(18'd50, 21'h4);
        read_chk("R9 fault seen before merge", 18'd50, 1'b0, 1'b0, 16'h1357, 1'b1);
        write(18'd50, 16'hE200, 1'b0, 1'b1);
        read_chk("R9 merged word clean", 18'd50, 1'b0, 1'b0, 16'hE257, 1'b0);
    endtask

    task automatic t_collide();
        write(18'd60, 16'h0F0F, 1'b0, 1'b0);
        @(negedge clk);
        cs_a_n = 1'b0; cs_b = 1'b1; wr_n = 1'b0; rd_n = 1'b1;
        hi_n = 1'b0; lo_n = 1'b0; addr = 18'd60; wdata = 16'hF00D;
        inj_en = 1'b1; inj_addr = 18'd60; inj_mask = 21'h100;
        @(negedge clk);
        idle();
        read_chk("R10 write beats injection", 18'd60, 1'b0, 1'b0, 16'hF00D, 1'b0);
        inject(18'd60, 21'h100);
        read_chk("R10 injection alone flags", 18'd60, 1'b0, 1'b0, 16'hF00D, 1'b1);
    endtask

    task automatic t_wrap();
        write(18'd5, 16'h2468, 1'b0, 1'b0);
        read_chk("R12 alias read", 18'(5 + DEPTH), 1'b0, 1'b0, 16'h2468, 1'b0);
        write(18'(7 + 3 * DEPTH), 16'h9753, 1'b0, 1'b0);
        read_chk("R12 alias write", 18'd7, 1'b0, 1'b0, 16'h9753, 1'b0);
    endtask

    initial begin
        idle();
        addr = '0; wdata = '0; inj_addr = '0; inj_mask = '0;
        rst = 1'b1;
        repeat (4) @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_full();
        t_bytes();
        t_quiet();
        t_write_wins();
        t_inject();
        t_partial_fix();
        t_collide();
        t_wrap();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule